// File: doc/BRIEF.md
# Asynchronous static RAM access sequencer

This block sits between a clocked host and an asynchronous static RAM of 262,144 words by 4 bits. The host hands over one word access at a time on a valid/ready port: an 18-bit address, 4-bit write data and a write flag. The sequencer then drives the memory's address and its three active-low strobes (chip select, write strobe, output enable) so that every analog timing limit of the memory holds. It returns read data with a single-cycle valid pulse.

Each limit is a parameter in picoseconds. The sequencer converts it to whole clock cycles for a parameterised clock period, always rounding up. Writes keep output enable high for the whole access, so the shorter write-pulse limit applies. The shared data bus is split into separate out, out-enable and in signals. The sequencer turns the bus around only after the memory's float time has passed, so the two drivers can never both be active. With the default 4 ns clock an access takes five cycles: one setup cycle, two strobe cycles and two turnaround cycles.

Top module: `sramc_top`

## Requirements
- R1: While reset is held, `reqReady` is low, `memCeN`, `memWeN` and `memOeN` are high, `memDqOe` is low, and a request has no effect.
- R2: `reqReady` is high only when no access is in progress. A request is accepted on a clock edge where `reqValid` and `reqReady` are both high. A `reqValid` held high during an access is ignored until the sequencer is idle again.
- R3: From the cycle after acceptance, `memAddr` carries the accepted address and holds it until the next acceptance. `memCeN` is low for the setup cycle and the strobe window, and high otherwise.
- R4: A write (`reqWrite` = 1) pulls `memWeN` low for ceil(max(write pulse, data setup) / clock) cycles, which is 2 at the defaults. The pulse starts one cycle after `memCeN` falls. `memOeN` stays high for the whole write.
- R5: The bus is driven (`memDqOe` high, carrying the accepted write data) exactly while `memWeN` is low. It is released on the same edge where `memWeN` rises.
- R6: A read (`reqWrite` = 0) pulls `memOeN` low for max(ceil(address access / clock) - 1, ceil(output-enable access / clock)) cycles, which is 2 at the defaults. During a read `memWeN` stays high and the bus is not driven.
- R7: Read data is sampled from `memDqIn` on the edge that ends the read strobe window. It is presented on `rdData` with `rdValid` high for exactly one cycle, the cycle right after that edge.
- R8: After the strobe window, all strobes stay high for a turnaround of max(ceil(float time / clock), ceil(cycle time / clock) - 1 - shorter strobe, 1) cycles, which is 2 at the defaults, before `reqReady` returns. The bus is never driven within the float time after `memOeN` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Sequencer idle, can accept |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 18 | Word address |
| reqWdata | input | 4 | Write data |
| rdValid | output | 1 | One-cycle read data valid |
| rdData | output | 4 | Read data |
| memAddr | output | 18 | Memory address |
| memCeN | output | 1 | Memory chip select, active low |
| memWeN | output | 1 | Memory write strobe, active low |
| memOeN | output | 1 | Memory output enable, active low |
| memDqOut | output | 4 | Data toward memory |
| memDqOe | output | 1 | Drive enable for memDqOut |
| memDqIn | input | 4 | Data from memory |

## Verification
Two events can fall on the same edge. The read-data return (capture plus the `rdValid` pulse) overlaps the turnaround, and a host request that is already waiting must neither be taken early nor be lost when the sequencer becomes idle. The bench provokes this by holding `reqValid` high continuously across back-to-back accesses and changing the payload right after each acceptance. A behavioural reference tracks the access phase from its own count of edges since acceptance and compares every memory pin, `reqReady`, `rdValid` and `rdData` on every clock. A memory model alongside it stores write data on the rising write strobe and flags short pulses, address changes during a write, and bus contention.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_TURN
  } phase_e;

  // strobes driven toward the memory pins
  typedef struct packed {
    logic ceN;
    logic weN;
    logic oeN;
    logic dqOe;
  } pin_strobe_t;

  // strobes from control to the datapath
  typedef struct packed {
    logic load;
    logic capture;
  } dp_ctl_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/sramc_ctrl.sv
module sramc_ctrl
  import sramc_pkg::*;
#(
  parameter int CLK_PS  = 4000,
  parameter int T_WP_PS = 8000,
  parameter int T_DS_PS = 5000,
  parameter int T_AA_PS = 10000,
  parameter int T_OE_PS = 5000,
  parameter int T_HZ_PS = 5000,
  parameter int T_RC_PS = 10000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  output logic        reqReady,
  output pin_strobe_t pins,
  output dp_ctl_t     dpCtl
);

  localparam int SETUP_CYC = 1;
  localparam int WR_CYC    = imax(ceilDiv(imax(T_WP_PS, T_DS_PS), CLK_PS), 1);
  localparam int RD_CYC    = imax(imax(ceilDiv(T_AA_PS, CLK_PS) - SETUP_CYC,
                                       ceilDiv(T_OE_PS, CLK_PS)), 1);
  localparam int TURN_CYC  = imax(imax(ceilDiv(T_HZ_PS, CLK_PS),
                                       ceilDiv(T_RC_PS, CLK_PS) - SETUP_CYC - imin(WR_CYC, RD_CYC)), 1);
  localparam int MAX_CYC   = imax(imax(WR_CYC, RD_CYC), imax(TURN_CYC, SETUP_CYC));
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LAST    = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LAST    = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LAST  = CNT_W'(TURN_CYC - 1);

  phase_e           state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic             opWr, opWrNext;
  logic             accept;
  pin_strobe_t      pinsNext;

  assign reqReady = rstN && (state == ST_IDLE);
  assign accept   = reqValid && reqReady;

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    opWrNext  = accept ? reqWrite : opWr;
    case (state)
      ST_IDLE: begin
        if (accept) begin
          stateNext = ST_SETUP;
          cntNext   = SETUP_LAST;
        end
      end
      ST_SETUP: begin
        if (cnt == '0) begin
          stateNext = ST_STROBE;
          cntNext   = opWr ? WR_LAST : RD_LAST;
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      ST_STROBE: begin
        if (cnt == '0) begin
          stateNext = ST_TURN;
          cntNext   = TURN_LAST;
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      default: begin
        if (cnt == '0) begin
          stateNext = ST_IDLE;
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
    endcase
  end

  always_comb begin
    pinsNext.ceN  = !((stateNext == ST_SETUP) || (stateNext == ST_STROBE));
    pinsNext.weN  = !((stateNext == ST_STROBE) && opWrNext);
    pinsNext.oeN  = !((stateNext == ST_STROBE) && !opWrNext);
    pinsNext.dqOe = (stateNext == ST_STROBE) && opWrNext;
  end

  assign dpCtl.load    = accept;
  assign dpCtl.capture = (state == ST_STROBE) && (cnt == '0) && !opWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      opWr  <= 1'b0;
      pins  <= '{ceN: 1'b1, weN: 1'b1, oeN: 1'b1, dqOe: 1'b0};
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
      opWr  <= opWrNext;
      pins  <= pinsNext;
    end
  end

  // checker: consecutive cycles with the write strobe low
  logic [7:0] weLowCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weLowCnt <= '0;
    end else if (!pins.weN) begin
      weLowCnt <= (weLowCnt == 8'hFF) ? weLowCnt : weLowCnt + 1'b1;
    end else begin
      weLowCnt <= '0;
    end
  end

  a_r4_we_width: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pins.weN) |-> (int'(weLowCnt) >= WR_CYC));

  a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    !pins.ceN |-> !reqReady);

endmodule

// File: rtl/sramc_datapath.sv
module sramc_datapath
  import sramc_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_ctl_t           dpCtl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr  <= '0;
      memDqOut <= '0;
    end else if (dpCtl.load) begin
      memAddr  <= reqAddr;
      memDqOut <= reqWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= dpCtl.capture;
      if (dpCtl.capture) begin
        rdData <= memDqIn;
      end
    end
  end

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  a_r3_no_load_while_valid: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> !dpCtl.load);

endmodule

// File: rtl/sramc_top.sv
module sramc_top
  import sramc_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int DATA_W  = 4,
  parameter int CLK_PS  = 4000,
  parameter int T_WP_PS = 8000,
  parameter int T_DS_PS = 5000,
  parameter int T_AA_PS = 10000,
  parameter int T_OE_PS = 5000,
  parameter int T_HZ_PS = 5000,
  parameter int T_RC_PS = 10000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  localparam int HZ_CYC = ceilDiv(T_HZ_PS, CLK_PS);

  pin_strobe_t pins;
  dp_ctl_t     dpCtl;

  sramc_ctrl #(
    .CLK_PS (CLK_PS),
    .T_WP_PS(T_WP_PS),
    .T_DS_PS(T_DS_PS),
    .T_AA_PS(T_AA_PS),
    .T_OE_PS(T_OE_PS),
    .T_HZ_PS(T_HZ_PS),
    .T_RC_PS(T_RC_PS)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .pins    (pins),
    .dpCtl   (dpCtl)
  );

  sramc_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .dpCtl   (dpCtl),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .memDqIn (memDqIn),
    .memAddr (memAddr),
    .memDqOut(memDqOut),
    .rdValid (rdValid),
    .rdData  (rdData)
  );

  assign memCeN  = pins.ceN;
  assign memWeN  = pins.weN;
  assign memOeN  = pins.oeN;
  assign memDqOe = pins.dqOe;

  // checker: cycles since output enable last went high
  logic [7:0] oeHighCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oeHighCnt <= 8'hFF;
    end else if (memOeN) begin
      oeHighCnt <= (oeHighCnt == 8'hFF) ? oeHighCnt : oeHighCnt + 1'b1;
    end else begin
      oeHighCnt <= '0;
    end
  end

  a_r4_oe_high_in_write: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memOeN);

  a_r4_we_needs_ce: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> !memCeN);

  a_r5_drive_only_we_low: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> !memWeN);

  a_r5_release_with_we: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> !memDqOe);

  a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && $past(!memCeN)) |-> $stable(memAddr));

  a_r7_capture_in_read: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> ($past(!memOeN) && memOeN));

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memCeN && memWeN && memOeN && !memDqOe));

  a_r8_float_before_drive: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memDqOe) |-> (int'(oeHighCnt) >= HZ_CYC));

endmodule

// File: tb/sramc_top_bench.sv
module sramc_top_bench;

  localparam int WR_CYC   = 2;
  localparam int RD_CYC   = 2;
  localparam int TURN_CYC = 2;
  localparam int HZ_CYC   = 2;
  localparam int STR_END  = 1 + 2;             // last strobe phase (equal lengths at defaults)
  localparam int LAST_PH  = 1 + 2 + TURN_CYC;  // last busy phase

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [17:0] reqAddr = '0;
  logic [3:0]  reqWdata = '0;
  logic        rdValid;
  logic [3:0]  rdData;
  logic [17:0] memAddr;
  logic        memCeN, memWeN, memOeN, memDqOe;
  logic [3:0]  memDqOut;
  logic [3:0]  memDqIn = '0;

  always #2 clk = ~clk;

  sramc_top u_sramc_top (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rdValid(rdValid), .rdData(rdData), .memAddr(memAddr),
    .memCeN(memCeN), .memWeN(memWeN), .memOeN(memOeN),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // reference: phase since acceptance, own copy of memory contents
  int          phase = 0;
  int          accCount = 0;
  logic        expWr = 1'b0;
  logic [17:0] expAddr = '0;
  logic [3:0]  expData = '0;
  logic [3:0]  refMem [int];

  always @(posedge clk) begin
    if (!rstN) begin
      phase = 0;
    end else if (phase == 0) begin
      if (reqValid) begin
        phase = 1;
        expWr = reqWrite;
        expAddr = reqAddr;
        expData = reqWdata;
        accCount++;
        if (reqWrite) refMem[int'(reqAddr)] = reqWdata;
      end
    end else if (phase == LAST_PH) begin
      phase = 0;
    end else begin
      phase++;
    end
  end

  function automatic logic [3:0] refRead(input logic [17:0] a);
    if (refMem.exists(int'(a))) return refMem[int'(a)];
    return 4'h0;
  endfunction

  // behavioural memory model with its own rule checks
  logic [3:0]  memArr [int];
  logic        prevWeN = 1'b1;
  int          weLow = 0;
  int          floatCnt = 99;
  logic [17:0] wAddr = '0;
  logic [3:0]  wData = '0;

  always @(negedge clk) begin
    if (rstN) begin
      // compare every pin against the reference phase
      bit inStrobe;
      bit expCeN, expWeN, expOeN, expOe, expRdy, expRv;
      inStrobe = (phase >= 2) && (phase <= STR_END);
      expCeN = !((phase >= 1) && (phase <= STR_END));
      expWeN = !(inStrobe && expWr);
      expOeN = !(inStrobe && !expWr);
      expOe  = inStrobe && expWr;
      expRdy = (phase == 0);
      expRv  = (phase == STR_END + 1) && !expWr;
      check(memCeN == expCeN, (phase > STR_END) ? "R8" : "R3", "memCeN", memCeN, expCeN);
      check(memWeN == expWeN, "R4", "memWeN", memWeN, expWeN);
      check(memOeN == expOeN, "R6", "memOeN", memOeN, expOeN);
      check(memDqOe == expOe, "R5", "memDqOe", memDqOe, expOe);
      check(reqReady == expRdy, "R2", "reqReady", reqReady, expRdy);
      check(memAddr == expAddr, "R3", "memAddr", memAddr, expAddr);
      check(rdValid == expRv, "R7", "rdValid", rdValid, expRv);
      if (expOe) check(memDqOut == expData, "R5", "memDqOut", memDqOut, expData);
      if (expRv) check(rdData == refRead(expAddr), "R7", "rdData", rdData, refRead(expAddr));

      // contention: bus driven while memory drives or within its float time
      check(!(memDqOe && (!memCeN && !memOeN && memWeN || floatCnt < HZ_CYC)),
            "R8", "contention", memDqOe, 0);

      // write strobe rules
      if (!memWeN) begin
        if (weLow > 0) check(memAddr == wAddr, "R3", "addr change in write", memAddr, wAddr);
        weLow++;
        wAddr = memAddr;
        wData = memDqOe ? memDqOut : 4'hX;
      end else if (!prevWeN) begin
        check(weLow >= WR_CYC, "R4", "write pulse cycles", weLow, WR_CYC);
        memArr[int'(wAddr)] = wData;
        weLow = 0;
      end
      prevWeN = memWeN;
    end else begin
      check(reqReady == 1'b0 && memCeN && memWeN && memOeN && !memDqOe && !rdValid,
            "R1", "reset state", {reqReady, memCeN, memWeN, memOeN, memDqOe, rdValid}, 6'b011100);
    end

    if (!memCeN && !memOeN && memWeN) begin
      floatCnt = 0;
      memDqIn = memArr.exists(int'(memAddr)) ? memArr[int'(memAddr)] : 4'h0;
    end else begin
      if (floatCnt < 99) floatCnt++;
      memDqIn = 4'h0;
    end
  end

  task automatic doAccess(input logic wr, input logic [17:0] a, input logic [3:0] d);
    int start;
    start = accCount;
    reqValid = 1'b1;
    reqWrite = wr;
    reqAddr  = a;
    reqWdata = d;
    while (accCount == start) @(negedge clk);
  endtask

  task automatic idle(input int n);
    reqValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    // R1: request held during reset must not start anything
    reqValid = 1'b1;
    reqWrite = 1'b1;
    reqAddr  = 18'h00123;
    repeat (4) @(negedge clk);
    reqValid = 1'b0;
    rstN = 1'b1;
    idle(3);
    check(phase == 0 && memCeN, "R1", "no access from reset-time request", memCeN, 1);

    // corner addresses, separated accesses (R4 R5 R6 R7)
    doAccess(1'b1, 18'h00000, 4'hA); idle(3);
    doAccess(1'b1, 18'h3FFFF, 4'h5); idle(3);
    doAccess(1'b0, 18'h00000, 4'h0); idle(3);
    doAccess(1'b0, 18'h3FFFF, 4'h0); idle(3);

    // back-to-back with valid held: request waits through rdValid and turnaround (R2 R8)
    doAccess(1'b1, 18'h00010, 4'h3);
    doAccess(1'b0, 18'h00010, 4'h0);
    doAccess(1'b1, 18'h00010, 4'hC);
    doAccess(1'b0, 18'h00010, 4'h0);
    doAccess(1'b0, 18'h3FFFF, 4'h0);
    idle(2);

    // random read-after-write over a small address pool
    for (int i = 0; i < 200; i++) begin
      logic [17:0] a;
      a = {$urandom_range(0, 3) == 0 ? 14'h3FFF : 14'h0000, 4'($urandom_range(0, 15))};
      doAccess(1'($urandom_range(0, 1)), a, 4'($urandom_range(0, 15)));
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 4));
    end
    idle(8);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule